// File: doc/BRIEF.md
# Serial Time Slot Interchange Core

This core moves eight-bit channels between sixteen serial receive lines and sixteen serial transmit lines. Each line carries 32 byte channels per frame, so there are 512 channels in and 512 channels out. A frame lasts 512 clocks, and each bit is held for two clocks. The core writes incoming bytes into one half of a two-half data store in the order they arrive. The other half supplies the outgoing bytes. The halves swap at each frame wrap, so any switched byte leaves exactly one frame after it arrived.

A connection table has one entry per output channel. Each entry gives the source channel, a bit that turns that output slot off, and a control bit. A second serial output runs at one bit per clock and plays back the control bits of all 512 entries during each frame. A frame pulse on `fsync` realigns the frame counter. The pulse may be active-low or active-high, and the core tells which from the pulse shape. The polarity decides where the counter restarts. Each transmit line has its own enable, `tx_oe`. It is on only when output is enabled globally (by pin or by register bit) and the current slot of that line is not turned off.

Top module: `tsi_core`

## Requirements
- R1: While `rst_n` is low, all `tx_oe` bits are 0 and `ctl_o` is 0. After release:
  - the frame clock is 0;
  - the read half is half 0;
  - all table entries, stored bytes and the drive bit are 0.
- R2: Frame clock k runs from 0 to 511.
  - Channel c of a receive line occupies clocks 16c to 16c+15.
  - Bit j (j=0 is the MSB) occupies clocks 16c+2j and 16c+2j+1.
  - The bit is sampled at the edge that ends the second of those two clocks.
- R3: Take table entry 32t+d whose source field is 32s+c. During channel d's clocks of frame F+1, transmit line t carries the byte received on line s, channel c, in frame F. Bit j of that byte is driven during clocks 16d+2j and 16d+2j+1, MSB first.
- R4: A write takes effect from the clock after its edge. When `cfg_we` is 1 and `cfg_addr[9]` is 0, entry `cfg_addr[8:0]` (index = 32·line + channel) receives `cfg_wdata`, with these fields:
  - `[8:0]`: source index;
  - `[9]`: slot off;
  - `[10]`: control bit.
- R5: All `tx_oe` bits are 0 unless `out_en` is 1 or the drive bit is 1. A write with `cfg_addr[9]`=1 loads the drive bit from `cfg_wdata[0]`.
- R6: When output is enabled globally, `tx_oe[t]` is 0 during the clocks of channel d exactly when entry 32t+d has its slot-off bit set. Otherwise it is 1.
- R7: During frame clock k, `ctl_o` equals the control bit of entry k.
- R8: Suppose `fsync` is sampled low at edge e and high at edges e-1 and e+1. Then the clock after edge e+2 is frame clock 2.
- R9: Suppose `fsync` is sampled high at edge e and low at edges e-1 and e+1. Then the clock after edge e+2 is frame clock 1.
- R10: Without such a pulse, the frame clock advances by one per clock and wraps from 511 to 0. The read and write halves swap only at that wrap.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Serial clock, two per data bit |
| rst_n | input | 1 | Asynchronous active-low reset |
| fsync | input | 1 | Frame pulse, either polarity |
| rx_i | input | 16 | Serial receive lines |
| out_en | input | 1 | Global transmit enable pin |
| cfg_we | input | 1 | Table or drive-bit write strobe |
| cfg_addr | input | 10 | Entry index; bit 9 selects the drive bit |
| cfg_wdata | input | 11 | Entry or drive-bit write data |
| tx_o | output | 16 | Serial transmit lines |
| tx_oe | output | 16 | Per-line drive enable, 0 means high-impedance |
| ctl_o | output | 1 | Control bit stream, one bit per clock |

## Verification
The bench targets several corner cases. Each one is listed with the failure it exposes:
- **Frame boundary.** This is where the data halves must swap. A design that swaps early, late or not at all would send either the current frame's bytes or stale bytes.
- **Pulse polarity.** Both polarities are driven, at arbitrary points in the frame. A design that ignores polarity or mistimes the reload would shift every slot and the control stream by a clock or more.
- **Enable mix.** The pin, the drive bit and the slot-off bit are varied together with writes to the table in mid-frame. A wrong combination would drive a line during a slot that should float, or float one that should drive.
- **Mid-run reset.** Reset is applied with the enable pin held high. It must float every line at once and clear the stored bytes.

// File: rtl/tsi_core.sv
module tsi_core #(
  parameter int STREAMS = 16,
  parameter int CHANS   = 32
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 fsync,
  input  logic [STREAMS-1:0]   rx_i,
  input  logic                 out_en,
  input  logic                 cfg_we,
  input  logic [$clog2(STREAMS*CHANS):0] cfg_addr,
  input  logic [$clog2(STREAMS*CHANS)+1:0] cfg_wdata,
  output logic [STREAMS-1:0]   tx_o,
  output logic [STREAMS-1:0]   tx_oe,
  output logic                 ctl_o
);
  localparam int SW    = $clog2(STREAMS);
  localparam int CW    = $clog2(CHANS);
  localparam int AW    = SW + CW;
  localparam int EW    = AW + 2;
  localparam int SLOTS = STREAMS * CHANS;
  localparam int CNTW  = CW + 4;
  localparam logic [CNTW-1:0] LAST = CNTW'(CHANS * 16 - 1);

  logic [CNTW-1:0] cnt_q;
  logic            half_q, drv_q;
  logic            fp1_q, fp2_q, fp3_q;
  logic [EW-1:0]   cm_q [SLOTS];
  logic [7:0]      dm_q [2*SLOTS];
  logic [6:0]      sh_q [STREAMS];

  wire           sync_hit = (fp2_q != fp3_q) && (fp1_q == fp3_q);
  wire [CW-1:0]  ch       = cnt_q[CNTW-1:4];
  wire [2:0]     bit_i    = cnt_q[3:1];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      half_q <= 1'b0;
      fp1_q  <= 1'b0;
      fp2_q  <= 1'b0;
      fp3_q  <= 1'b0;
    end else begin
      fp1_q <= fsync;
      fp2_q <= fp1_q;
      fp3_q <= fp2_q;
      if (sync_hit)
        cnt_q <= fp2_q ? CNTW'(1) : CNTW'(2);
      else if (cnt_q == LAST) begin
        cnt_q  <= '0;
        half_q <= ~half_q;
      end else
        cnt_q <= cnt_q + CNTW'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int s = 0; s < STREAMS; s++) sh_q[s] <= '0;
      for (int a = 0; a < 2*SLOTS; a++) dm_q[a] <= '0;
    end else begin
      for (int s = 0; s < STREAMS; s++) begin
        if (cnt_q[0]) sh_q[s] <= {sh_q[s][5:0], rx_i[s]};
        if (cnt_q[3:0] == 4'hF) dm_q[{~half_q, SW'(s), ch}] <= {sh_q[s], rx_i[s]};
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      drv_q <= 1'b0;
      for (int a = 0; a < SLOTS; a++) cm_q[a] <= '0;
    end else if (cfg_we) begin
      if (cfg_addr[AW]) drv_q <= cfg_wdata[0];
      else              cm_q[cfg_addr[AW-1:0]] <= cfg_wdata;
    end
  end

  for (genvar s = 0; s < STREAMS; s++) begin : g_tx
    wire [EW-1:0] ent    = cm_q[{SW'(s), ch}];
    wire [7:0]    byte_o = dm_q[{half_q, ent[AW-1:0]}];
    assign tx_o[s]  = byte_o[3'd7 - bit_i];
    assign tx_oe[s] = rst_n & (out_en | drv_q) & ~ent[AW];
  end

  assign ctl_o = cm_q[AW'(cnt_q)][AW+1];
endmodule

// File: rtl/tsi_core_chk.sv
module tsi_core_chk #(
  parameter int STREAMS = 16,
  parameter int CNTW    = 9
) (
  input logic               clk,
  input logic               rst_n,
  input logic               out_en,
  input logic               drv,
  input logic               sync_hit,
  input logic               sync_pol,
  input logic               half,
  input logic [CNTW-1:0]    cnt,
  input logic [STREAMS-1:0] tx_oe,
  input logic               ctl_o
);
  always @(posedge clk) begin
    if (!rst_n) begin
      AST_RST_HIZ: assert (tx_oe == '0);  // R1
      AST_RST_CTL: assert (ctl_o == 1'b0); // R1
    end
  end

  AST_OE_GLOBAL: assert property (@(posedge clk) disable iff (!rst_n)
    (!out_en && !drv) |-> tx_oe == '0); // R5

  AST_SYNC_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    (sync_hit && !sync_pol) |=> cnt == CNTW'(2)); // R8

  AST_SYNC_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
    (sync_hit && sync_pol) |=> cnt == CNTW'(1)); // R9

  AST_CNT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    !sync_hit |=> cnt == CNTW'($past(cnt) + CNTW'(1))); // R10

  AST_HALF_SWAP: assert property (@(posedge clk) disable iff (!rst_n)
    (!sync_hit && cnt == '1) |=> half != $past(half)); // R10

  AST_HALF_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (sync_hit || cnt != '1) |=> $stable(half)); // R10
endmodule

bind tsi_core tsi_core_chk #(.STREAMS(STREAMS), .CNTW(CNTW)) u_chk (
  .clk(clk), .rst_n(rst_n), .out_en(out_en), .drv(drv_q),
  .sync_hit(sync_hit), .sync_pol(fp2_q), .half(half_q), .cnt(cnt_q),
  .tx_oe(tx_oe), .ctl_o(ctl_o)
);

// File: tb/tb_tsi_core.sv
module tb_tsi_core;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        fsync = 1'b1;
  logic [15:0] rx_i = '0;
  logic        out_en = 1'b0;
  logic        cfg_we = 1'b0;
  logic [9:0]  cfg_addr = '0;
  logic [10:0] cfg_wdata = '0;
  logic [15:0] tx_o, tx_oe;
  logic        ctl_o;

  int checks = 0, errors = 0;
  bit finished = 0;

  tsi_core dut (
    .clk(clk), .rst_n(rst_n), .fsync(fsync), .rx_i(rx_i), .out_en(out_en),
    .cfg_we(cfg_we), .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata),
    .tx_o(tx_o), .tx_oe(tx_oe), .ctl_o(ctl_o)
  );

  always #2 clk = ~clk;

  int m_cm[512];
  int m_dm[1024];
  int m_sh[16];
  int m_cnt, m_half, m_drv;
  bit h1, h2, h3;

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  always @(posedge clk) begin
    if (!rst_n) begin
      foreach (m_cm[i]) m_cm[i] = 0;
      foreach (m_dm[i]) m_dm[i] = 0;
      foreach (m_sh[i]) m_sh[i] = 0;
      m_cnt = 0; m_half = 0; m_drv = 0;
      h1 = 0; h2 = 0; h3 = 0;
    end else begin
      bit sync;
      sync = (h2 != h3) && (h1 == h3);
      if (m_cnt % 2 == 1) begin
        for (int s = 0; s < 16; s++) begin
          int b;
          b = ((m_sh[s] << 1) | rx_i[s]) & 255;
          if (m_cnt % 16 == 15) m_dm[(1 - m_half) * 512 + s * 32 + m_cnt / 16] = b;
          m_sh[s] = b;
        end
      end
      if (cfg_we) begin
        if (cfg_addr >= 512) m_drv = cfg_wdata & 1;
        else m_cm[cfg_addr] = cfg_wdata;
      end
      if (sync) m_cnt = h2 ? 1 : 2;
      else if (m_cnt == 511) begin m_cnt = 0; m_half = 1 - m_half; end
      else m_cnt++;
      h3 = h2; h2 = h1; h1 = fsync;
    end
  end

  always @(negedge clk) begin
    if (!finished) begin
      if (!rst_n) begin
        chk(tx_oe == 16'h0, "R1 tx_oe in reset", tx_oe, 0);
        chk(ctl_o == 1'b0, "R1 ctl_o in reset", ctl_o, 0);
      end else begin
        logic [15:0] eo, ed;
        bit ec;
        for (int s = 0; s < 16; s++) begin
          int e;
          e = m_cm[s * 32 + m_cnt / 16];
          eo[s] = (out_en || m_drv != 0) && ((e >> 9) & 1) == 0;
          ed[s] = (m_dm[m_half * 512 + (e & 511)] >> (7 - ((m_cnt >> 1) & 7))) & 1;
        end
        ec = (m_cm[m_cnt] >> 10) & 1;
        chk(tx_oe == eo, "R5 R6 tx_oe", tx_oe, eo);
        chk(((tx_o ^ ed) & eo) == 0, "R3 R4 R10 tx_o", tx_o & eo, ed & eo);
        chk(ctl_o == ec, "R7 ctl_o", ctl_o, ec);
      end
    end
  end

  task automatic step();
    @(posedge clk);
    #1;
  endtask

  task automatic wr(input int addr, input int data);
    cfg_we = 1'b1; cfg_addr = 10'(addr); cfg_wdata = 11'(data);
    step();
    cfg_we = 1'b0;
  endtask

  task automatic summary();
    finished = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  initial begin
    #(200000 * 4);
    errors++;
    $display("FAIL watchdog expired actual=running expected=done");
    summary();
  end

  initial begin
    logic [7:0] pat, got;
    repeat (4) step();
    chk(tx_oe == 16'h0, "R1 tx_oe after reset", tx_oe, 0);
    rst_n = 1'b1;
    step();
    chk(ctl_o == 1'b0 && tx_oe == 16'h0, "R1 state after release", {tx_oe, ctl_o}, 0);

    // R4: program every entry, control bit only on entry 2
    for (int i = 0; i < 512; i++)
      wr(i, ((i == 2) << 10) | (((i % 5) == 4) << 9) | ((i * 37 + 11) % 512));
    wr(3 * 32 + 5, 7 * 32 + 2);
    out_en = 1'b1;

    // R2 R3: byte on line 7 channel 2 reappears on line 3 channel 5 next frame
    pat = 8'hA5;
    do step(); while (m_cnt != 0);
    for (int k = 0; k < 512; k++) begin
      rx_i = 16'($urandom);
      if ((m_cnt >> 4) == 2) rx_i[7] = pat[7 - ((m_cnt >> 1) & 7)];
      step();
    end
    got = '0;
    for (int k = 0; k < 512; k++) begin
      if ((m_cnt >> 4) == 5 && (m_cnt % 2) == 1) begin
        got[7 - ((m_cnt >> 1) & 7)] = tx_o[3];
        chk(tx_oe[3] == 1'b1, "R6 line 3 slot 5 driven", tx_oe[3], 1);
      end
      rx_i = 16'($urandom);
      step();
    end
    chk(got == pat, "R2 R3 one-frame switched byte", got, pat);

    // R8: active-low pulse with idle high
    fsync = 1'b0; step();
    fsync = 1'b1; step();
    step();
    chk(ctl_o == 1'b1, "R8 low pulse gives frame clock 2", ctl_o, 1);
    step();
    chk(ctl_o == 1'b0, "R8 next clock is frame clock 3", ctl_o, 0);

    // R9: active-high pulse with idle low, control bit now on entry 1
    wr(2, (2 * 37 + 11) % 512);
    wr(1, (1 << 10) | ((1 * 37 + 11) % 512));
    fsync = 1'b0;
    repeat (5) step();
    fsync = 1'b1; step();
    fsync = 1'b0; step();
    step();
    chk(ctl_o == 1'b1, "R9 high pulse gives frame clock 1", ctl_o, 1);
    step();
    chk(ctl_o == 1'b0, "R9 next clock is frame clock 2", ctl_o, 0);

    // R5: enable pin low, drive bit clear -> all floating
    out_en = 1'b0; step();
    chk(tx_oe == 16'h0, "R5 pin and drive bit low", tx_oe, 0);
    wr(512, 1); 
    chk(tx_oe != 16'h0, "R5 drive bit alone enables", tx_oe, 16'hffff);
    wr(512, 0);
    chk(tx_oe == 16'h0, "R5 drive bit cleared", tx_oe, 0);

    // mixed traffic: writes, enables, pulses of both polarities (R4 to R10)
    begin
      bit idle;
      idle = 1'b0;
      for (int k = 0; k < 4000; k++) begin
        rx_i = 16'($urandom);
        out_en = ($urandom % 8) != 0;
        cfg_we = ($urandom % 12) == 0;
        cfg_addr = (($urandom % 30) == 0) ? 10'd512 : 10'($urandom % 512);
        cfg_wdata = 11'($urandom);
        if (($urandom % 1500) == 0) idle = ~idle;
        fsync = idle ^ (($urandom % 700) == 0);
        step();
      end
      cfg_we = 1'b0;
      fsync = idle;
    end

    // R1: reset mid-run with pin enable high
    out_en = 1'b1;
    rst_n = 1'b0;
    repeat (3) step();
    rst_n = 1'b1;
    for (int k = 0; k < 600; k++) begin
      rx_i = 16'($urandom);
      step();
    end
    summary();
  end
endmodule